// File: doc/BRIEF.md
# SVGA Extended Register Lock and Memory Segment Banking

This block is the host-facing port logic of a VGA-compatible display controller. It decodes 8-bit I/O port writes and reads and keeps four kinds of state. The first is a two-register unlock sequence that arms or disarms an extension key. The second is an indexed CRTC register file of 64 bytes with write protection. The third is a pair of raw segment-select latches. The fourth is the read and write bank base addresses, 21 bits each, that the memory path uses to place a 64 KB host window inside video memory.

Writes to the extended CRTC registers and to the bank bases have no effect until software performs the unlock sequence. A port at 0x3DF, with an alias at 0x3BF, holds a compatibility byte. A write to the mode port 0x3D8 compares the new byte with that compatibility byte and then sets, clears or keeps the key. The legacy protect bit, bit 7 of CRTC entry 0x11, guards the timing registers separately from the key. Reads return 0 on any port the block does not decode.

Top module: `svga_unlock_bank`

## Requirements
- R1: After reset the key is clear, both bank bases are 0, all 64 CRTC entries read 0, the CRTC index reads 0, and both segment latches read 0.
- R2: A write to port 0x3DF sets the compatibility byte. Port 0x3BF is an alias of 0x3DF only while bit 0 of the last byte written to port 0x3C2 is 1. Otherwise writes to 0x3BF are ignored.
- R3: A write of byte M to port 0x3D8 sets the key when the compatibility byte equals 0x03 and bits 7 and 5 of M are both 1.
- R4: A write of byte M to port 0x3D8 clears the key when the compatibility byte differs from 0x03 and bits 7 and 5 of M are not both 1. In every other case the key keeps its value.
- R5: Port 0x3D4 writes and reads the 6-bit CRTC index, which reads back with bits 7:6 at 0. Port 0x3D5 writes and reads the entry at that index.
- R6: While bit 7 of CRTC entry 0x11 is 1, writes to entries 0x00 through 0x06 and to entry 0x35 are discarded.
- R7: While bit 7 of CRTC entry 0x11 is 1, a write to entry 0x07 replaces only bit 4. The other seven bits keep their old values.
- R8: While the key is clear, writes to entries above 0x18 are discarded, except entries 0x33 and 0x35.
- R9: Port 0x3CD latches its raw byte, which reads back from that port. When banking is enabled, the write bank base bits 19:16 take bits 3:0 of the byte and the read bank base bits 19:16 take bits 7:4. Bit 20 and bits 15:0 stay as they were; bits 15:0 are always 0.
- R10: Port 0x3CB latches its raw byte, which reads back from that port. When banking is enabled, bit 0 of the byte becomes write bank base bit 20 and bit 4 becomes read bank base bit 20.
- R11: Banking is enabled only while the key is set and bit 4 of CRTC entry 0x36 is 0. When it is not enabled, writes to 0x3CD and 0x3CB still latch their bytes but leave both bank bases unchanged.
- R12: An accepted write to CRTC entry 0x36 with bit 4 clear recomputes both bank bases from the two latched segment bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| rd_en | input | 1 | Host read strobe |
| port_addr | input | 16 | I/O port address |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Read data, combinational from port_addr while rd_en is 1, otherwise 0 |
| key_o | output | 1 | Extension key state |
| wr_bank | output | 21 | Write bank base byte address |
| rd_bank | output | 21 | Read bank base byte address |
| crtc_flat | output | 512 | All CRTC entries, entry n at bits 8n+7:8n |

## Verification
On every cycle the assertions check that a discarded CRTC write leaves the whole register file unchanged. This covers both the legacy protect window and the key-gated upper range. They also check the bit-4-only merge into entry 0x07, the key-set rule, and that the segment ports move the bank bases only when banking is enabled. The bench scenarios cover what the properties cannot easily express. These are the effect of the 0x3C2 decode bit on the 0x3BF alias, which shows only through later key behaviour, and the hold cases of the key rule. They also cover the exceptions 0x33 and 0x35 under a clear key, and the recompute of the bank bases from the latched bytes when entry 0x36 is rewritten.

// File: rtl/svga_ub_pkg.sv
package svga_ub_pkg;
  localparam int DATA_W    = 8;
  localparam int SEG_SHIFT = 16;
  localparam int SEG_W     = 5;
  localparam int BANK_W    = SEG_SHIFT + SEG_W;

  localparam logic [15:0] P_HCOMPAT   = 16'h03DF;
  localparam logic [15:0] P_HCOMPAT_M = 16'h03BF;
  localparam logic [15:0] P_MISC      = 16'h03C2;
  localparam logic [15:0] P_MODE      = 16'h03D8;
  localparam logic [15:0] P_CIDX      = 16'h03D4;
  localparam logic [15:0] P_CDAT      = 16'h03D5;
  localparam logic [15:0] P_SEG       = 16'h03CD;
  localparam logic [15:0] P_SEGX      = 16'h03CB;

  localparam logic [7:0] IX_PROT  = 8'h11;
  localparam logic [7:0] IX_OVFL  = 8'h07;
  localparam logic [7:0] IX_TOPLK = 8'h18;
  localparam logic [7:0] IX_FREE  = 8'h33;
  localparam logic [7:0] IX_PLK   = 8'h35;
  localparam logic [7:0] IX_BANK  = 8'h36;
  localparam logic [7:0] UNLOCK_HCOMPAT = 8'h03;
  localparam logic [7:0] UNLOCK_MASK    = 8'hA0;

  function automatic logic key_next(input logic [7:0] hcompat,
                                    input logic [7:0] mode_new,
                                    input logic key_cur);
    logic both;
    both = (mode_new & UNLOCK_MASK) == UNLOCK_MASK;
    if (hcompat == UNLOCK_HCOMPAT) return both ? 1'b1 : key_cur;
    return both ? key_cur : 1'b0;
  endfunction

  function automatic logic crtc_wr_ok(input logic [7:0] idx,
                                      input logic prot,
                                      input logic key);
    if (prot && ((idx < IX_OVFL) || (idx == IX_PLK))) return 1'b0;
    if (!key && (idx > IX_TOPLK) && (idx != IX_FREE) && (idx != IX_PLK))
      return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [7:0] crtc_merge(input logic [7:0] idx,
                                            input logic prot,
                                            input logic [7:0] old_v,
                                            input logic [7:0] new_v);
    if (prot && (idx == IX_OVFL)) return {old_v[7:5], new_v[4], old_v[3:0]};
    return new_v;
  endfunction

  function automatic logic [BANK_W-1:0] seg_to_base(input logic [SEG_W-1:0] seg);
    return {seg, {SEG_SHIFT{1'b0}}};
  endfunction
endpackage

// File: rtl/ub_key_tracker.sv
module ub_key_tracker
  import svga_ub_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              hc_we,
  input  logic              mode_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] hcompat_q,
  output logic              key_q
);
  logic [DATA_W-1:0] mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hcompat_q <= '0;
      mode_q    <= '0;
      key_q     <= 1'b0;
    end else begin
      if (hc_we) hcompat_q <= wdata;
      if (mode_we) begin
        mode_q <= wdata;
        key_q  <= key_next(hcompat_q, wdata, key_q);
      end
    end
  end

  logic unused_mode;
  assign unused_mode = ^mode_q;
endmodule

// File: rtl/ub_crtc_file.sv
module ub_crtc_file
  import svga_ub_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    idx_we,
  input  logic [IDX_W-1:0]        idx_wdata,
  input  logic                    data_we,
  input  logic [DATA_W-1:0]       wdata,
  input  logic                    key,
  output logic [IDX_W-1:0]        idx_q,
  output logic [DATA_W-1:0]       sel_data,
  output logic [DEPTH*DATA_W-1:0] flat,
  output logic                    prot,
  output logic                    bank_lock,
  output logic                    commit,
  output logic                    bank_recalc
);
  logic [DATA_W-1:0] regs [DEPTH];
  logic [7:0]        idx8;

  assign idx8        = 8'(idx_q);
  assign prot        = regs[int'(IX_PROT)][7];
  assign bank_lock   = regs[int'(IX_BANK)][4];
  assign sel_data    = regs[idx_q];
  assign commit      = data_we && crtc_wr_ok(idx8, prot, key);
  assign bank_recalc = commit && (idx8 == IX_BANK) && !wdata[4];

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else begin
      if (idx_we) idx_q <= idx_wdata;
      if (commit) regs[idx_q] <= crtc_merge(idx8, prot, regs[idx_q], wdata);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign flat[g*DATA_W +: DATA_W] = regs[g];
  end
endmodule

// File: rtl/ub_bank_unit.sv
module ub_bank_unit
  import svga_ub_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              seg_we,
  input  logic              segx_we,
  input  logic              upd_en,
  input  logic              recalc,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] seg_raw,
  output logic [DATA_W-1:0] segx_raw,
  output logic [SEG_W-1:0]  wr_seg,
  output logic [SEG_W-1:0]  rd_seg
);
  always_ff @(posedge clk) begin
    if (rst) begin
      seg_raw  <= '0;
      segx_raw <= '0;
      wr_seg   <= '0;
      rd_seg   <= '0;
    end else begin
      if (seg_we) begin
        seg_raw <= wdata;
        if (upd_en) begin
          wr_seg[3:0] <= wdata[3:0];
          rd_seg[3:0] <= wdata[7:4];
        end
      end
      if (segx_we) begin
        segx_raw <= wdata;
        if (upd_en) begin
          wr_seg[4] <= wdata[0];
          rd_seg[4] <= wdata[4];
        end
      end
      if (recalc) begin
        wr_seg <= {segx_raw[0], seg_raw[3:0]};
        rd_seg <= {segx_raw[4], seg_raw[7:4]};
      end
    end
  end
endmodule

// File: rtl/svga_unlock_bank.sv
module svga_unlock_bank
  import svga_ub_pkg::*;
#(
  parameter int CRTC_DEPTH = 64,
  localparam int IDX_W = $clog2(CRTC_DEPTH)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic                         rd_en,
  input  logic [15:0]                  port_addr,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [DATA_W-1:0]            rd_data,
  output logic                         key_o,
  output logic [BANK_W-1:0]            wr_bank,
  output logic [BANK_W-1:0]            rd_bank,
  output logic [CRTC_DEPTH*DATA_W-1:0] crtc_flat
);
  logic              mono_alias_q;
  logic [DATA_W-1:0] hcompat_q;
  logic [IDX_W-1:0]  crtc_idx;
  logic [DATA_W-1:0] crtc_sel;
  logic              crtc_prot, bank_lock, crtc_commit, bank_recalc;
  logic [DATA_W-1:0] seg_raw, segx_raw;
  logic [SEG_W-1:0]  wr_seg, rd_seg;
  logic              bank_upd_en;

  logic hit_hc, hit_misc, hit_mode, hit_cidx, hit_cdat, hit_seg, hit_segx;
  assign hit_hc   = (port_addr == P_HCOMPAT) ||
                    ((port_addr == P_HCOMPAT_M) && mono_alias_q);
  assign hit_misc = port_addr == P_MISC;
  assign hit_mode = port_addr == P_MODE;
  assign hit_cidx = port_addr == P_CIDX;
  assign hit_cdat = port_addr == P_CDAT;
  assign hit_seg  = port_addr == P_SEG;
  assign hit_segx = port_addr == P_SEGX;

  always_ff @(posedge clk) begin
    if (rst) mono_alias_q <= 1'b0;
    else if (wr_en && hit_misc) mono_alias_q <= wr_data[0];
  end

  ub_key_tracker u_key (
    .clk(clk), .rst(rst),
    .hc_we(wr_en && hit_hc), .mode_we(wr_en && hit_mode),
    .wdata(wr_data), .hcompat_q(hcompat_q), .key_q(key_o)
  );

  ub_crtc_file #(.DEPTH(CRTC_DEPTH)) u_crtc (
    .clk(clk), .rst(rst),
    .idx_we(wr_en && hit_cidx), .idx_wdata(wr_data[IDX_W-1:0]),
    .data_we(wr_en && hit_cdat), .wdata(wr_data), .key(key_o),
    .idx_q(crtc_idx), .sel_data(crtc_sel), .flat(crtc_flat),
    .prot(crtc_prot), .bank_lock(bank_lock),
    .commit(crtc_commit), .bank_recalc(bank_recalc)
  );

  assign bank_upd_en = key_o && !bank_lock;

  ub_bank_unit u_bank (
    .clk(clk), .rst(rst),
    .seg_we(wr_en && hit_seg), .segx_we(wr_en && hit_segx),
    .upd_en(bank_upd_en), .recalc(bank_recalc), .wdata(wr_data),
    .seg_raw(seg_raw), .segx_raw(segx_raw),
    .wr_seg(wr_seg), .rd_seg(rd_seg)
  );

  assign wr_bank = seg_to_base(wr_seg);
  assign rd_bank = seg_to_base(rd_seg);

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      if (hit_cidx)      rd_data = DATA_W'(crtc_idx);
      else if (hit_cdat) rd_data = crtc_sel;
      else if (hit_seg)  rd_data = seg_raw;
      else if (hit_segx) rd_data = segx_raw;
    end
  end

  logic unused_top;
  assign unused_top = crtc_commit ^ hit_hc;
endmodule

// File: rtl/svga_ub_checker.sv
module svga_ub_checker
  import svga_ub_pkg::*;
#(
  parameter int CRTC_DEPTH = 64,
  localparam int IDX_W = $clog2(CRTC_DEPTH)
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         wr_en,
  input logic [15:0]                  port_addr,
  input logic [DATA_W-1:0]            wr_data,
  input logic                         key_o,
  input logic [DATA_W-1:0]            hcompat_q,
  input logic [IDX_W-1:0]             crtc_idx,
  input logic [CRTC_DEPTH*DATA_W-1:0] crtc_flat,
  input logic [BANK_W-1:0]            wr_bank,
  input logic [BANK_W-1:0]            rd_bank
);
  logic prot_bit, lock_bit;
  logic [7:0] ix8;
  assign prot_bit = crtc_flat[8*int'(IX_PROT) + 7];
  assign lock_bit = crtc_flat[8*int'(IX_BANK) + 4];
  assign ix8      = 8'(crtc_idx);

  assert_key_set_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && port_addr == P_MODE && hcompat_q == UNLOCK_HCOMPAT &&
     wr_data[7] && wr_data[5]) |=> key_o);

  assert_prot_discard_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && port_addr == P_CDAT && prot_bit &&
     (ix8 < IX_OVFL || ix8 == IX_PLK)) |=> $stable(crtc_flat));

  assert_ovfl_merge_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && port_addr == P_CDAT && prot_bit && ix8 == IX_OVFL) |=>
    (crtc_flat[63:61] == $past(crtc_flat[63:61]) &&
     crtc_flat[59:56] == $past(crtc_flat[59:56]) &&
     crtc_flat[60] == $past(wr_data[4])));

  assert_key_discard_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && port_addr == P_CDAT && !key_o && ix8 > IX_TOPLK &&
     ix8 != IX_FREE && ix8 != IX_PLK) |=> $stable(crtc_flat));

  assert_seg_update_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && port_addr == P_SEG && key_o && !lock_bit) |=>
    (wr_bank[19:16] == $past(wr_data[3:0]) &&
     rd_bank[19:16] == $past(wr_data[7:4]) &&
     $stable(wr_bank[20]) && $stable(rd_bank[20])));

  assert_segx_update_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && port_addr == P_SEGX && key_o && !lock_bit) |=>
    (wr_bank[20] == $past(wr_data[0]) && rd_bank[20] == $past(wr_data[4])));

  assert_bank_frozen_R11: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (port_addr == P_SEG || port_addr == P_SEGX) &&
     (!key_o || lock_bit)) |=> ($stable(wr_bank) && $stable(rd_bank)));
endmodule

bind svga_unlock_bank svga_ub_checker #(.CRTC_DEPTH(CRTC_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .port_addr(port_addr),
  .wr_data(wr_data), .key_o(key_o), .hcompat_q(hcompat_q),
  .crtc_idx(crtc_idx), .crtc_flat(crtc_flat),
  .wr_bank(wr_bank), .rd_bank(rd_bank)
);

// File: tb/tb_svga_unlock_bank.sv
module tb_svga_unlock_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] port_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        key_o;
  logic [20:0] wr_bank, rd_bank;
  logic [511:0] crtc_flat;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  svga_unlock_bank dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .port_addr(port_addr), .wr_data(wr_data), .rd_data(rd_data),
    .key_o(key_o), .wr_bank(wr_bank), .rd_bank(rd_bank),
    .crtc_flat(crtc_flat)
  );

  function automatic logic [20:0] base_of(input logic hi, input logic [3:0] nib);
    return (21'(hi) << 20) | (21'(nib) << 16);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic io_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    port_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic io_rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    port_addr = a; rd_en = 1'b1;
    #1 d = rd_data;
    rd_en = 1'b0;
  endtask

  task automatic crtc_wr(input logic [7:0] ix, input logic [7:0] d);
    io_wr(16'h03D4, ix);
    io_wr(16'h03D5, d);
  endtask

  task automatic crtc_rd(input logic [7:0] ix, output logic [7:0] d);
    io_wr(16'h03D4, ix);
    io_rd(16'h03D5, d);
  endtask

  task automatic unlock();
    io_wr(16'h03DF, 8'h03);
    io_wr(16'h03D8, 8'hA0);
  endtask

  task automatic relock();
    io_wr(16'h03DF, 8'h00);
    io_wr(16'h03D8, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 key", key_o, 0);
    chk("R1 wr_bank", wr_bank, 0);
    chk("R1 rd_bank", rd_bank, 0);
    chk("R1 crtc", (crtc_flat == '0), 1);
    io_rd(16'h03D4, v); chk("R1 index", v, 0);
    io_rd(16'h03CD, v); chk("R1 seg", v, 0);
    io_rd(16'h03CB, v); chk("R1 segx", v, 0);
  endtask

  task automatic t_key();
    io_wr(16'h03DF, 8'h03);
    io_wr(16'h03D8, 8'h20);
    chk("R4 no set with one bit", key_o, 0);
    io_wr(16'h03D8, 8'hA0);
    chk("R3 set", key_o, 1);
    io_wr(16'h03D8, 8'h20);
    chk("R4 hold hc=3", key_o, 1);
    io_wr(16'h03DF, 8'h01);
    io_wr(16'h03D8, 8'hA0);
    chk("R4 hold both bits", key_o, 1);
    io_wr(16'h03D8, 8'h80);
    chk("R4 clear", key_o, 0);
  endtask

  task automatic t_alias();
    io_wr(16'h03C2, 8'h00);
    io_wr(16'h03DF, 8'h03);
    io_wr(16'h03BF, 8'h00);
    io_wr(16'h03D8, 8'hA0);
    chk("R2 alias off ignored", key_o, 1);
    relock();
    io_wr(16'h03C2, 8'h01);
    io_wr(16'h03DF, 8'h03);
    io_wr(16'h03BF, 8'h00);
    io_wr(16'h03D8, 8'hA0);
    chk("R2 alias on overwrites", key_o, 0);
    io_wr(16'h03BF, 8'h03);
    io_wr(16'h03D8, 8'hA0);
    chk("R2 alias on sets", key_o, 1);
  endtask

  task automatic t_crtc();
    logic [7:0] v;
    crtc_wr(8'h02, 8'h5A);
    io_rd(16'h03D4, v); chk("R5 index rb", v, 8'h02);
    io_rd(16'h03D5, v); chk("R5 data rb", v, 8'h5A);
    io_wr(16'h03D4, 8'hC5);
    io_rd(16'h03D4, v); chk("R5 index 6 bits", v, 8'h05);
    crtc_wr(8'h35, 8'h11);
    crtc_wr(8'h07, 8'hFF);
    crtc_wr(8'h11, 8'h80);
    crtc_wr(8'h02, 8'h33);
    crtc_rd(8'h02, v); chk("R6 idx2 kept", v, 8'h5A);
    crtc_wr(8'h35, 8'h22);
    crtc_rd(8'h35, v); chk("R6 idx35 kept", v, 8'h11);
    crtc_wr(8'h07, 8'h00);
    crtc_rd(8'h07, v); chk("R7 bit4 only clear", v, 8'hEF);
    crtc_wr(8'h07, 8'h10);
    crtc_rd(8'h07, v); chk("R7 bit4 only set", v, 8'hFF);
    crtc_wr(8'h08, 8'h77);
    crtc_rd(8'h08, v); chk("R6 idx8 open", v, 8'h77);
    relock();
    crtc_wr(8'h20, 8'h44);
    crtc_rd(8'h20, v); chk("R8 idx20 locked", v, 8'h00);
    crtc_wr(8'h3F, 8'h12);
    crtc_rd(8'h3F, v); chk("R8 idx3F locked", v, 8'h00);
    crtc_wr(8'h33, 8'h55);
    crtc_rd(8'h33, v); chk("R8 idx33 open", v, 8'h55);
    crtc_wr(8'h18, 8'h66);
    crtc_rd(8'h18, v); chk("R8 idx18 open", v, 8'h66);
    crtc_wr(8'h11, 8'h00);
    crtc_wr(8'h35, 8'h99);
    crtc_rd(8'h35, v); chk("R8 idx35 open", v, 8'h99);
  endtask

  task automatic t_bank();
    logic [7:0] v;
    io_wr(16'h03CD, 8'h53);
    io_rd(16'h03CD, v); chk("R11 seg latched", v, 8'h53);
    chk("R11 wr frozen key", wr_bank, 0);
    io_wr(16'h03CB, 8'h11);
    io_rd(16'h03CB, v); chk("R11 segx latched", v, 8'h11);
    chk("R11 rd frozen key", rd_bank, 0);
    unlock();
    io_wr(16'h03CD, 8'h53);
    chk("R9 wr base", wr_bank, base_of(1'b0, 4'h3));
    chk("R9 rd base", rd_bank, base_of(1'b0, 4'h5));
    io_wr(16'h03CB, 8'h10);
    chk("R10 wr bit20", wr_bank, base_of(1'b0, 4'h3));
    chk("R10 rd bit20", rd_bank, base_of(1'b1, 4'h5));
    io_wr(16'h03CB, 8'h01);
    chk("R10 wr bit20 b", wr_bank, base_of(1'b1, 4'h3));
    chk("R10 rd bit20 b", rd_bank, base_of(1'b0, 4'h5));
    crtc_wr(8'h36, 8'h10);
    io_wr(16'h03CD, 8'hF7);
    chk("R11 wr frozen lock", wr_bank, base_of(1'b1, 4'h3));
    chk("R11 rd frozen lock", rd_bank, base_of(1'b0, 4'h5));
    io_rd(16'h03CD, v); chk("R9 raw rb", v, 8'hF7);
    crtc_wr(8'h36, 8'h00);
    chk("R12 wr recompute", wr_bank, base_of(1'b1, 4'h7));
    chk("R12 rd recompute", rd_bank, base_of(1'b0, 4'hF));
    relock();
    io_wr(16'h03CD, 8'h00);
    chk("R11 frozen after relock", wr_bank, base_of(1'b1, 4'h7));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_key();
    t_alias();
    t_crtc();
    t_bank();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule